// File: doc/BRIEF.md
# Prescaled Periodic Down-Counting Timer

This block is a single-channel timer on a simple register bus. A 24-bit counter counts down once per tick. A prescaler makes the ticks by dividing the input clock by a programmable value plus one. Software programs a starting count and a control word, then reads the live count through a data register. Elapsed time is the difference between two reads.

In periodic mode the counter returns to the programmed starting count after it passes zero and keeps running. Software can then treat the count as a free-running 24-bit down counter. In one-shot mode the counter stops at zero and the block clears its own enable. The normal set-up sequence has three writes: clear the control word, write the starting count, then write the control word with enable set. That last write restarts both the count and the prescaler.

Top module: `tick_down_timer`

## Requirements
- R1: After synchronous reset every readable register returns zero.
- R2: The control register is at offset 0x00. Bit 30 is the enable, bit 27 selects periodic mode (1) or one-shot mode (0), and bits 7:0 hold the prescale value P. All other control bits read back as zero.
- R3: The starting-count register is at offset 0x08 and holds 24 bits. Its bits 31:24 read as zero. The live count is read at offset 0x10 and is read-only. Any other address reads as zero.
- R4: Read data is registered. The value on the read port after a clock edge is the content of the register addressed during that edge, as it stood just before the edge.
- R5: A write to the control register that sets the enable while the enable is clear loads the counter from the starting-count register and restarts the prescaler phase.
- R6: While enabled, the count drops by exactly one every P+1 clocks. The first decrement lands P+1 clocks after the start edge.
- R7: In periodic mode, the tick that finds the count at zero reloads the starting count. The sequence therefore repeats every (start+1)*(P+1) clocks.
- R8: In one-shot mode, the tick that brings the count to zero (or finds it there) leaves it at zero and clears the enable.
- R9: A control write with the enable set while the timer is already enabled does not reload the counter. Counting continues from its present value.
- R10: A control write with the enable clear stops the counter, and the count then holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock, the clock the prescaler divides |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |

## Verification
The assertions assume that bus writes are single-cycle strobes with a stable address. They also assume that the prescale value and the starting count are constant while the timer runs, so each step and reload checks against the values in the registers. The stimulus keeps to this: it changes the prescale and starting count only after writing zero to the control word. The one exception is a deliberate re-write of an identical control word while running. The sweep covers every prescale from 0 to 3 against starting counts 0, 1, 2 and 5 in both modes. It compares each cycle's count against a closed-form value built from the start edge.

// File: rtl/tdt_pkg.sv
package tdt_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 5;
  localparam int CNT_W    = 24;
  localparam int PSC_W    = 8;
  localparam int RUN_BIT  = 30;
  localparam int MODE_BIT = 27;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_LOAD  = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_COUNT = 5'h10;
endpackage

// File: rtl/tdt_regs.sv
module tdt_regs
  import tdt_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int PW = PSC_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctrl_wr,
  input  logic          load_wr,
  input  logic          wr_run,
  input  logic          wr_mode,
  input  logic [PW-1:0] wr_psc,
  input  logic [CW-1:0] wr_load,
  input  logic          self_stop,
  output logic          run,
  output logic          periodic,
  output logic [PW-1:0] psc,
  output logic [CW-1:0] load_val,
  output logic          start
);

  assign start = ctrl_wr && wr_run && !run;

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      periodic <= 1'b0;
      psc      <= '0;
      load_val <= '0;
    end else begin
      if (ctrl_wr) begin
        run      <= wr_run;
        periodic <= wr_mode;
        psc      <= wr_psc;
      end else if (self_stop) begin
        run <= 1'b0;
      end
      if (load_wr) begin
        load_val <= wr_load;
      end
    end
  end

  // R8
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (self_stop && !ctrl_wr) |=> !run);

  // R10
  stop_write_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !wr_run) |=> !run);

endmodule

// File: rtl/tdt_prescaler.sv
module tdt_prescaler
  import tdt_pkg::*;
#(
  parameter int PW = PSC_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          restart,
  input  logic [PW-1:0] psc,
  output logic          tick
);

  logic [PW-1:0] phase;

  assign tick = run && !restart && (phase >= psc);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
    end else if (restart || !run || tick) begin
      phase <= '0;
    end else begin
      phase <= phase + PW'(1);
    end
  end

  // R6
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !restart && !tick) |=> (phase == $past(phase) + PW'(1)));

  // R5
  phase_restart_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (phase == '0));

endmodule

// File: rtl/tdt_counter.sv
module tdt_counter
  import tdt_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          tick,
  input  logic          periodic,
  output logic [CW-1:0] cnt,
  output logic          self_stop
);

  logic at_zero;

  assign at_zero   = (cnt == '0);
  assign self_stop = tick && !periodic && (cnt <= CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (tick) begin
      if (at_zero) begin
        cnt <= periodic ? load_val : '0;
      end else begin
        cnt <= cnt - CW'(1);
      end
    end
  end

  // R6
  dec_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && !at_zero) |=> (cnt == $past(cnt) - CW'(1)));

  // R7
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && at_zero && periodic) |=> (cnt == $past(load_val)));

  // R8
  floor_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && at_zero && !periodic) |=> (cnt == '0));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> $stable(cnt));

  // R5
  load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == $past(load_val)));

endmodule

// File: rtl/tick_down_timer.sv
module tick_down_timer
  import tdt_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int CW = CNT_W,
  parameter int PW = PSC_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata
);

  localparam int CNT_PAD = DW - CW;

  logic          ctrl_wr, load_wr;
  logic          run, periodic, start, tick, self_stop;
  logic [PW-1:0] psc;
  logic [CW-1:0] load_val, cnt;
  logic [DW-1:0] ctrl_word;
  logic          unused_wdata;

  assign unused_wdata = ^bus_wdata;
  assign ctrl_wr = bus_we && (bus_addr == AW'(OFS_CTRL));
  assign load_wr = bus_we && (bus_addr == AW'(OFS_LOAD));

  tdt_regs #(.CW(CW), .PW(PW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .ctrl_wr  (ctrl_wr),
    .load_wr  (load_wr),
    .wr_run   (bus_wdata[RUN_BIT]),
    .wr_mode  (bus_wdata[MODE_BIT]),
    .wr_psc   (bus_wdata[PW-1:0]),
    .wr_load  (bus_wdata[CW-1:0]),
    .self_stop(self_stop),
    .run      (run),
    .periodic (periodic),
    .psc      (psc),
    .load_val (load_val),
    .start    (start)
  );

  tdt_prescaler #(.PW(PW)) u_psc (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .restart(start),
    .psc    (psc),
    .tick   (tick)
  );

  tdt_counter #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (start),
    .load_val (load_val),
    .tick     (tick),
    .periodic (periodic),
    .cnt      (cnt),
    .self_stop(self_stop)
  );

  always_comb begin
    ctrl_word           = '0;
    ctrl_word[RUN_BIT]  = run;
    ctrl_word[MODE_BIT] = periodic;
    ctrl_word[PW-1:0]   = psc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        AW'(OFS_CTRL):  bus_rdata <= ctrl_word;
        AW'(OFS_LOAD):  bus_rdata <= {{CNT_PAD{1'b0}}, load_val};
        AW'(OFS_COUNT): bus_rdata <= {{CNT_PAD{1'b0}}, cnt};
        default:        bus_rdata <= '0;
      endcase
    end
  end

  // R2
  ctrl_reserved_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == AW'(OFS_CTRL)) |=> (bus_rdata[MODE_BIT-1:PW] == '0));

  // R4
  count_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == AW'(OFS_COUNT)) |=> (bus_rdata == {{CNT_PAD{1'b0}}, $past(cnt)}));

  // R3
  load_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == AW'(OFS_LOAD)) |=> (bus_rdata[DW-1:CW] == '0));

endmodule

// File: tb/tick_down_timer_bench.sv
module tick_down_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_CTRL  = 5'h00;
  localparam logic [4:0] A_LOAD  = 5'h08;
  localparam logic [4:0] A_COUNT = 5'h10;
  localparam logic [4:0] A_HOLE  = 5'h04;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = A_COUNT;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_down_timer u_tick_down_timer (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );

  function automatic logic [31:0] ctrl_val(input bit en, input bit per, input int p);
    return (32'(en) << 30) | (32'(per) << 27) | 32'(p & 8'hFF);
  endfunction

  function automatic int exp_count(input int init, input int p, input bit per, input int n);
    int k;
    k = n / (p + 1);
    if (per) return init - (k % (init + 1));
    return (k >= init) ? 0 : init - k;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the write edge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_we    = 1'b1;
    bus_wdata = d;
    @(negedge clk);
    bus_we   = 1'b0;
    bus_addr = A_COUNT;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_addr = A_COUNT;
  endtask

  initial begin
    repeat (CLK_PERIOD * 200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int inits [4] = '{0, 1, 2, 5};
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset values
    rd(A_CTRL, v);  check("R1 ctrl", v, 32'h0);
    rd(A_LOAD, v);  check("R1 load", v, 32'h0);
    rd(A_COUNT, v); check("R1 count", v, 32'h0);

    // R3: 24-bit start register, hole reads zero
    wr(A_LOAD, 32'hFFFF_FFFF);
    rd(A_LOAD, v); check("R3 load width", v, 32'h00FF_FFFF);
    rd(A_HOLE, v); check("R3 hole", v, 32'h0);

    // R2: control layout and reserved bits
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, v); check("R2 ctrl readback", v, 32'h4800_00FF);
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, v); check("R2 ctrl cleared", v, 32'h0);

    // R4 R5 R6 R7 R8: sweep of prescale, start count and mode
    for (int per = 0; per < 2; per++) begin
      for (int p = 0; p < 4; p++) begin
        for (int i = 0; i < 4; i++) begin
          wr(A_CTRL, 32'h0);
          wr(A_LOAD, 32'(inits[i]));
          wr(A_CTRL, ctrl_val(1'b1, per[0], p));
          for (int m = 1; m <= 30; m++) begin
            @(negedge clk);
            check(per != 0 ? "R7 periodic count" : "R8 oneshot count",
                  bus_rdata, 32'(exp_count(inits[i], p, per[0], m - 1)));
          end
          rd(A_CTRL, v);
          check("R8 enable after run", v, ctrl_val(per[0], per[0], p));
        end
      end
    end

    // R10: stop freezes the count
    wr(A_CTRL, 32'h0);
    wr(A_LOAD, 32'd100);
    wr(A_CTRL, ctrl_val(1'b1, 1'b1, 0));
    for (int m = 1; m <= 10; m++) begin
      @(negedge clk);
      check("R6 count", bus_rdata, 32'(100 - (m - 1)));
    end
    wr(A_CTRL, 32'h0);
    for (int m = 0; m < 5; m++) begin
      @(negedge clk);
      check("R10 frozen", bus_rdata, 32'd89);
    end

    // R9: re-writing enable while running does not reload
    wr(A_CTRL, ctrl_val(1'b1, 1'b1, 0));
    for (int m = 1; m <= 5; m++) begin
      @(negedge clk);
      check("R5 restart", bus_rdata, 32'(100 - (m - 1)));
    end
    wr(A_CTRL, ctrl_val(1'b1, 1'b1, 0));
    for (int m = 7; m <= 12; m++) begin
      @(negedge clk);
      check("R9 no reload", bus_rdata, 32'(100 - (m - 1)));
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule